// File: doc/BRIEF.md
# Thermal Drift Tap Compensator

This block follows the die temperature while a memory interface is in normal operation and steers a fine read-capture delay line to cancel thermal drift. A memory controller raises a sample enable once a refresh or ZQ command has gone out and all outstanding read data has left the data bus. It keeps the enable high until that command finishes. The block looks at the 12-bit temperature code only on the clock where this enable rises.

Until calibration is reported done, enable edges are ignored. The first edge after that stores the temperature as the reference and moves nothing. On each later edge the current code is compared with the reference. If the temperature has risen by more than a threshold, the block sends one decrement request to the delay line. If it has fallen by more than the threshold, it sends one increment request. After either move the reference shifts one threshold step toward the current code.

The block keeps a signed count of the taps it has moved and stops at a configurable bound in each direction. Each request is a single-cycle pulse. The block then waits for a single-cycle acknowledge before it can move again. Because at most one tap moves per edge, a large temperature step is worked off over several refresh windows.

Top module: `thermal_tap_tracker`

## Requirements
- R1: The temperature is sampled only on a clock where `sample_en` is high and was low on the previous clock. An enable held high produces no further samples. An enable that is already high when reset is released does not count as a rising edge.
- R2: While `cal_done` is low, enable edges are ignored: no request is issued and no reference is stored.
- R3: The first enable edge with `cal_done` high stores `temp_code` as the reference and issues no request.
- R4: On a later edge, a current code greater than the reference plus `STEP` (default 10) issues a decrement request. A code less than the reference minus `STEP` issues an increment request. A difference of exactly `STEP` or less in magnitude issues nothing.
- R5: After a decrement the reference rises by `STEP`, and after an increment it falls by `STEP`.
- R6: A request is a one-cycle pulse on `tap_inc_req` or `tap_dec_req`. It is high in the cycle after the clock on which the enable rose. The two requests are never high together.
- R7: After a request, no further request is issued until `tap_ack` has been seen. Enable edges that arrive while waiting move nothing and leave the reference unchanged.
- R8: The net tap count (increments minus decrements) stays within ±`MAX_TAPS` (default 16). A request that would step past the bound is suppressed, and the reference does not change.
- R9: At most one tap moves per enable edge.
- R10: A synchronous active-high `rst` clears the stored baseline, the tap count and any pending request wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_done | input | 1 | High once calibration has finished |
| sample_en | input | 1 | Bus-idle window enable from the controller; its rising edge samples |
| temp_code | input | 12 | Current die temperature code |
| tap_inc_req | output | 1 | One-cycle request to add one fine delay tap |
| tap_dec_req | output | 1 | One-cycle request to remove one fine delay tap |
| tap_ack | input | 1 | One-cycle acknowledge from the delay line |

## Verification
The hardest state to reach from the ports is the negative tap bound. To get there, the reference must be walked up one step per enable edge, and each step needs its own acknowledge. The stimulus first baselines at a mid-scale code. It then holds a far higher code and repeats the edge-then-acknowledge cycle until the decrement pulses stop, and it counts exactly how many arrived. A second subtle state is an edge that lands during the wait for acknowledge. The bench raises the enable again without acknowledging and confirms that the later edge, after the acknowledge, moves from the unchanged reference.

// File: rtl/ttt_pkg.sv
package ttt_pkg;
    // Width of the temperature code bus.
    localparam int TEMP_W = 12;

    // Tap move chosen in a cycle.
    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_UP   = 2'd1,
        MV_DOWN = 2'd2
    } move_e;
endpackage

// File: rtl/tt_rise_detect.sv
module tt_rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise
);
    logic seen_q;
    logic seen_d;

    always_comb begin
        seen_d = level;
    end

    // During reset the level is tracked, so an enable held high across the
    // release of reset is not taken for a rising edge (R1).
    always_ff @(posedge clk) begin
        seen_q <= seen_d;
    end

    assign rise = level && !seen_q && !rst;
endmodule

// File: rtl/tt_drift_cmp.sv
module tt_drift_cmp #(
    parameter int TEMP_W = 12,
    parameter int STEP   = 10
) (
    input  logic [TEMP_W-1:0] cur,
    input  logic [TEMP_W-1:0] ref_t,
    output logic              hot,
    output logic              cold
);
    localparam logic signed [TEMP_W:0] LIM = (TEMP_W+1)'(STEP);

    logic signed [TEMP_W:0] diff;

    always_comb begin
        diff = $signed({1'b0, cur}) - $signed({1'b0, ref_t});
        hot  = diff > LIM;
        cold = diff < -LIM;
    end
endmodule

// File: rtl/tt_tap_limit.sv
module tt_tap_limit #(
    parameter int TAP_W    = 6,
    parameter int MAX_TAPS = 16
) (
    input  logic signed [TAP_W-1:0] taps,
    output logic                    can_up,
    output logic                    can_down
);
    localparam logic signed [TAP_W-1:0] HI = TAP_W'(MAX_TAPS);
    localparam logic signed [TAP_W-1:0] LO = -HI;

    always_comb begin
        can_up   = taps < HI;
        can_down = taps > LO;
    end
endmodule

// File: rtl/thermal_tap_tracker.sv
module thermal_tap_tracker
    import ttt_pkg::*;
#(
    parameter int STEP     = 10,
    parameter int MAX_TAPS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cal_done,
    input  logic              sample_en,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              tap_inc_req,
    output logic              tap_dec_req,
    input  logic              tap_ack
);
    localparam int TAP_W = $clog2(MAX_TAPS + 1) + 1;
    localparam logic signed [TAP_W-1:0] TAP_HI  = TAP_W'(MAX_TAPS);
    localparam logic signed [TAP_W-1:0] TAP_LO  = -TAP_HI;
    localparam logic signed [TAP_W-1:0] TAP_ONE = TAP_W'(1);
    localparam logic [TEMP_W-1:0]       STEP_T  = TEMP_W'(STEP);

    typedef struct packed {
        logic                    base_ok;
        logic [TEMP_W-1:0]       ref_t;
        logic signed [TAP_W-1:0] taps;
        logic                    busy;
        logic                    inc;
        logic                    dec;
    } state_t;

    state_t s_q, s_d;
    logic   en_rise;
    logic   hot, cold;
    logic   can_up, can_down;
    move_e  move;

    tt_rise_detect u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (sample_en),
        .rise  (en_rise)
    );

    tt_drift_cmp #(.TEMP_W(TEMP_W), .STEP(STEP)) u_cmp (
        .cur   (temp_code),
        .ref_t (s_q.ref_t),
        .hot   (hot),
        .cold  (cold)
    );

    tt_tap_limit #(.TAP_W(TAP_W), .MAX_TAPS(MAX_TAPS)) u_lim (
        .taps     (s_q.taps),
        .can_up   (can_up),
        .can_down (can_down)
    );

    always_comb begin
        s_d     = s_q;
        s_d.inc = 1'b0;
        s_d.dec = 1'b0;
        move    = MV_NONE;

        if (s_q.busy && tap_ack) begin
            s_d.busy = 1'b0;
        end

        if (en_rise && cal_done) begin
            if (!s_q.base_ok) begin
                s_d.base_ok = 1'b1;
                s_d.ref_t   = temp_code;
            end else if (!s_q.busy) begin
                if (hot && can_down) begin
                    move = MV_DOWN;
                end else if (cold && can_up) begin
                    move = MV_UP;
                end
            end
        end

        case (move)
            MV_DOWN: begin
                s_d.dec   = 1'b1;
                s_d.busy  = 1'b1;
                s_d.ref_t = s_q.ref_t + STEP_T;
                s_d.taps  = s_q.taps - TAP_ONE;
            end
            MV_UP: begin
                s_d.inc   = 1'b1;
                s_d.busy  = 1'b1;
                s_d.ref_t = s_q.ref_t - STEP_T;
                s_d.taps  = s_q.taps + TAP_ONE;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.base_ok <= 1'b0;
            s_q.ref_t   <= '0;
            s_q.taps    <= '0;
            s_q.busy    <= 1'b0;
            s_q.inc     <= 1'b0;
            s_q.dec     <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign tap_inc_req = s_q.inc;
    assign tap_dec_req = s_q.dec;

    // R1: a request can only follow a clock where the enable had just risen
    a_r1_edge_only: assert property (@(posedge clk) disable iff (rst)
        (tap_inc_req || tap_dec_req) |-> ($past(sample_en) && !$past(sample_en, 2)));

    // R2: nothing moves while calibration is not done
    a_r2_wait_cal: assert property (@(posedge clk) disable iff (rst)
        !cal_done |=> !(tap_inc_req || tap_dec_req));

    // R3: without a baseline no request can follow
    a_r3_baseline_first: assert property (@(posedge clk) disable iff (rst)
        !s_q.base_ok |=> !(tap_inc_req || tap_dec_req));

    // R5: each decrement raises the reference by one step
    a_r5_ref_shift: assert property (@(posedge clk) disable iff (rst)
        tap_dec_req |-> (s_q.ref_t == $past(s_q.ref_t) + STEP_T));

    // R6: pulses last one cycle and never overlap
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (tap_inc_req || tap_dec_req) |=> !(tap_inc_req || tap_dec_req));
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(tap_inc_req && tap_dec_req));

    // R7: while waiting for acknowledge no new request appears
    a_r7_hold_for_ack: assert property (@(posedge clk) disable iff (rst)
        (s_q.busy && !tap_ack) |=> !(tap_inc_req || tap_dec_req));

    // R8: tap count stays inside the bound
    a_r8_tap_bound: assert property (@(posedge clk) disable iff (rst)
        (s_q.taps <= TAP_HI) && (s_q.taps >= TAP_LO));

    // R9: a move changes the count by exactly one
    a_r9_single_step: assert property (@(posedge clk) disable iff (rst)
        tap_inc_req |-> (s_q.taps == $past(s_q.taps) + TAP_ONE));
endmodule

// File: tb/tb_thermal_tap_tracker.sv
module tb_thermal_tap_tracker;
    localparam int STEP = 10;
    localparam int MAXT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cal_done = 1'b0;
    logic        sample_en = 1'b0;
    logic [11:0] temp_code = '0;
    logic        tap_ack = 1'b0;
    logic        tap_inc_req, tap_dec_req;

    int checks = 0;
    int fails  = 0;

    // bench model state
    bit m_base = 0;
    int m_ref  = 0;
    int m_taps = 0;
    bit m_busy = 0;

    always #4 clk = ~clk;

    thermal_tap_tracker #(.STEP(STEP), .MAX_TAPS(MAXT)) dut (
        .clk         (clk),
        .rst         (rst),
        .cal_done    (cal_done),
        .sample_en   (sample_en),
        .temp_code   (temp_code),
        .tap_inc_req (tap_inc_req),
        .tap_dec_req (tap_dec_req),
        .tap_ack     (tap_ack)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int req_code();
        return {30'd0, tap_inc_req, tap_dec_req};
    endfunction

    // expected code: 0 none, 1 decrement, 2 increment
    function automatic int model_edge(int t);
        int r;
        r = 0;
        if (!cal_done) return 0;
        if (!m_base) begin
            m_base = 1;
            m_ref  = t;
            return 0;
        end
        if (m_busy) return 0;
        if (t - m_ref > STEP && m_taps > -MAXT) begin
            r = 1; m_ref += STEP; m_taps--; m_busy = 1;
        end else if (m_ref - t > STEP && m_taps < MAXT) begin
            r = 2; m_ref -= STEP; m_taps++; m_busy = 1;
        end
        return r;
    endfunction

    // one enable window: rise, check pulse, check it drops, release
    task automatic window(int t, string req, output int got);
        int exp;
        @(negedge clk);
        temp_code = t[11:0];
        sample_en = 1'b1;
        exp = model_edge(t);
        @(posedge clk); #1;
        got = req_code();
        check(req, got, exp);
        @(posedge clk); #1;
        check("R6 pulse one cycle", req_code(), 0);
        @(negedge clk);
        sample_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk);
        tap_ack = 1'b1;
        m_busy  = 0;
        @(negedge clk);
        tap_ack = 1'b0;
    endtask

    task automatic t_reset_state();
        check("R10 reset outputs", req_code(), 0);
    endtask

    task automatic t_before_cal();
        int g;
        window(500, "R2 ignored before cal", g);
        window(3000, "R2 ignored before cal", g);
    endtask

    task automatic t_baseline();
        int g;
        cal_done = 1'b1;
        window(1000, "R3 baseline no move", g);
    endtask

    task automatic t_level_hold();
        @(negedge clk);
        temp_code = 12'd1100;
        sample_en = 1'b1;
        // edge inside window: expected a decrement (R4)
        void'(model_edge(1100));
        @(posedge clk); #1;
        check("R4 rise decrement", req_code(), 1);
        for (int i = 0; i < 20; i++) begin
            @(posedge clk); #1;
            check("R1 level high no resample", req_code(), 0);
        end
        @(negedge clk);
        sample_en = 1'b0;
        ack();
    endtask

    task automatic t_threshold();
        int g;
        // reference now 1010
        window(1020, "R4 exactly STEP no move", g);
        window(1021, "R4 rise beyond STEP", g);
        ack();
        // reference 1020; 1009 is 11 below
        window(1009, "R4 fall gives increment", g);
        ack();
        // reference 1010 (R5); 1000 is exactly STEP below
        window(1000, "R5 ref shifted, no move", g);
    endtask

    task automatic t_busy();
        int g;
        window(1030, "R7 first move", g);
        window(1050, "R7 edge while waiting ignored", g);
        ack();
        window(1050, "R7 move after ack from unchanged ref", g);
        ack();
    endtask

    task automatic t_bound();
        int g;
        int pulses = 0;
        for (int i = 0; i < 24; i++) begin
            window(4000, "R9 one move per edge", g);
            if (g != 0) pulses++;
            ack();
        end
        // taps were -3, bound -16: exactly 13 more decrements
        check("R8 decrements up to bound", pulses, 13);
        check("R8 model at bound", m_taps, -MAXT);
    endtask

    task automatic t_mid_reset();
        int g;
        @(negedge clk);
        rst = 1'b1;
        sample_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_base = 0; m_taps = 0; m_busy = 0; m_ref = 0;
        @(posedge clk); #1;
        check("R1 high across reset no edge", req_code(), 0);
        @(posedge clk); #1;
        check("R1 high across reset no edge", req_code(), 0);
        @(negedge clk);
        sample_en = 1'b0;
        @(negedge clk);
        window(200, "R10 baseline cleared", g);
        window(4000, "R10 taps cleared, move allowed", g);
        ack();
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst = 1'b0;
                @(negedge clk); #1;
                t_reset_state();
                t_before_cal();
                t_baseline();
                t_level_hold();
                t_threshold();
                t_busy();
                t_bound();
                t_mid_reset();
            end
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule